// File: doc/BRIEF.md
# Dual-Register-Window Serial Slave Interface

This block is the register front end that one upstream serial-bus port sees. It works on an already decoded byte stream: a start pulse (also used for repeated starts), a stop pulse, a received-byte strobe with its byte, and a strobe that marks the end of each byte sent back to the master. For every received byte it decides whether to acknowledge. After the address byte, a write transfer sends one command byte. This byte selects one of three registers and can turn on pointer auto-increment. The registers are an interrupt-enable register, a control register and a status register. The status register is read-only and comes from outside the block.

The 7-bit slave address is a fixed prefix of three ones followed by four strap inputs. A master normally writes the command byte, then issues a repeated start and reads. It can also stream data bytes into the writable registers. When auto-increment is on, the pointer moves on after each byte. On reads it wraps back to the first register. On writes it stops at the status register, and writes there are refused.

Top module: `regsel_slave`

## Requirements
- R1: An address byte is acknowledged only when bits [7:1] equal {3'b111, strap_i}. On a mismatch it is not acknowledged and every later byte is ignored (no ack_valid_o) until the next start.
- R2: Address bit 0 selects the direction: 1 starts a read transfer (tx_byte_o drives the selected register), and 0 expects a command byte.
- R3: A command byte is acknowledged only when bits [7:5] and [3:2] are zero and bits [1:0] are not 2'b11. Bit 4 is the auto-increment flag. A rejected command byte leaves the stored pointer and flag unchanged.
- R4: Pointer 2'b00 selects the interrupt-enable register and 2'b01 selects the control register. A data byte written to either one is acknowledged and stored.
- R5: Pointer 2'b10 selects the status register (stat_i). A data byte written there is not acknowledged, changes no register, and ends the transfer.
- R6: With auto-increment set, each completed read byte advances the pointer 00→01→10→00.
- R7: With auto-increment set, each written data byte advances the pointer but holds it at 10.
- R8: With auto-increment clear, the pointer stays the same across consecutive data bytes in both directions.
- R9: Reset clears the pointer, the auto-increment flag and both writable registers, so a read with no command byte returns the interrupt-enable register.
- R10: A repeated start keeps the stored pointer, so a command-byte write followed by a repeated-start read returns the chosen register.
- R11: ack_valid_o pulses in the cycle after each accepted rx_valid_i, and ack_o is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated-start detected |
| stop_i | input | 1 | Stop detected |
| rx_valid_i | input | 1 | A received byte is on rx_byte_i |
| rx_byte_i | input | 8 | Received byte |
| rd_done_i | input | 1 | The byte on tx_byte_o has been shifted out |
| strap_i | input | 4 | Address strap inputs |
| stat_i | input | 8 | Status register contents |
| tx_byte_o | output | 8 | Byte to send on a read |
| ack_valid_o | output | 1 | An ack decision is presented |
| ack_o | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| ie_o | output | 8 | Interrupt-enable register |
| ctrl_o | output | 8 | Control register |

## Verification
The bench uses the default configuration: a fixed prefix of 3'b111 and four strap bits. At this size every one of the 256 address bytes is tried under four strap settings. All 256 command bytes are also swept, and each accepted code is followed by a repeated-start read that confirms which register it selected. Directed sequences then walk the pointer through read wrap-around, write saturation at the status register and fixed-pointer streaming.

// File: rtl/regsel_pkg.sv
package regsel_pkg;
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WDATA, S_RDATA} state_e;

  localparam int PTR_W = 2;
  localparam logic [PTR_W-1:0] PTR_IE   = 2'd0;
  localparam logic [PTR_W-1:0] PTR_CTRL = 2'd1;
  localparam logic [PTR_W-1:0] PTR_STAT = 2'd2;
  localparam int AI_BIT = 4;

  function automatic logic cmd_ok(input logic [7:0] c);
    return (c[7:5] == 3'b000) && (c[3:2] == 2'b00) && (c[1:0] != 2'b11);
  endfunction
endpackage

// File: rtl/regsel_addr_match.sv
module regsel_addr_match #(
  parameter int FIX_W = 3,
  parameter logic [FIX_W-1:0] FIX_VAL = '1,
  parameter int STRAP_W = 4
) (
  input  logic [FIX_W+STRAP_W-1:0] addr_i,
  input  logic [STRAP_W-1:0]       strap_i,
  output logic                     hit_o
);
  assign hit_o = (addr_i == {FIX_VAL, strap_i});
endmodule

// File: rtl/regsel_ptr.sv
module regsel_ptr
  import regsel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             ai_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             step_wr_i,
  input  logic             step_rd_i,
  output logic             ai_o,
  output logic [PTR_W-1:0] ptr_o
);
  logic             ai_q;
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ai_q  <= 1'b0;
      ptr_q <= PTR_IE;
    end else if (load_i) begin
      ai_q  <= ai_i;
      ptr_q <= ptr_i;
    end else if (ai_q && step_wr_i) begin
      ptr_q <= (ptr_q == PTR_STAT) ? PTR_STAT : PTR_W'(ptr_q + 1'b1); // sticks on writes
    end else if (ai_q && step_rd_i) begin
      ptr_q <= (ptr_q == PTR_STAT) ? PTR_IE : PTR_W'(ptr_q + 1'b1);   // wraps on reads
    end
  end

  assign ai_o  = ai_q;
  assign ptr_o = ptr_q;

  p_ptr_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q != 2'b11);
  p_rd_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_wr_i && step_rd_i && ai_q && ptr_q == PTR_STAT) |=> ptr_q == PTR_IE);
  p_wr_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_wr_i && ai_q && ptr_q == PTR_STAT) |=> ptr_q == PTR_STAT);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !ai_q && (step_wr_i || step_rd_i)) |=> $stable(ptr_q));
endmodule

// File: rtl/regsel_bank.sv
module regsel_bank
  import regsel_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0] ie_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ie_q, ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      if (ptr_i == PTR_IE)   ie_q   <= wdata_i;
      if (ptr_i == PTR_CTRL) ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    case (ptr_i)
      PTR_IE:   rdata_o = ie_q;
      PTR_CTRL: rdata_o = ctrl_q;
      default:  rdata_o = stat_i;
    endcase
  end

  assign ie_o   = ie_q;
  assign ctrl_o = ctrl_q;

  p_ro_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(ie_q) && $stable(ctrl_q)));
endmodule

// File: rtl/regsel_slave.sv
module regsel_slave
  import regsel_pkg::*;
#(
  parameter int FIX_W = 3,
  parameter logic [FIX_W-1:0] FIX_VAL = '1,
  parameter int STRAP_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_byte_i,
  input  logic               rd_done_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [7:0]         stat_i,
  output logic [7:0]         tx_byte_o,
  output logic               ack_valid_o,
  output logic               ack_o,
  output logic [7:0]         ie_o,
  output logic [7:0]         ctrl_o
);
  localparam int ADDR_W = FIX_W + STRAP_W;

  state_e           state_q;
  logic             ack_q, ack_valid_q;
  logic             hit, byte_in, load, wr_en, step_wr, step_rd, ai;
  logic [PTR_W-1:0] ptr;

  regsel_addr_match #(.FIX_W(FIX_W), .FIX_VAL(FIX_VAL), .STRAP_W(STRAP_W)) u_match (
    .addr_i (rx_byte_i[ADDR_W:1]),
    .strap_i(strap_i),
    .hit_o  (hit)
  );

  // a byte strobe counts only when no bus condition overrides it
  assign byte_in = rx_valid_i && !start_i && !stop_i;
  assign load    = byte_in && (state_q == S_CMD) && cmd_ok(rx_byte_i);
  assign step_wr = byte_in && (state_q == S_WDATA);
  assign wr_en   = step_wr && (ptr != PTR_STAT);
  assign step_rd = rd_done_i && !start_i && !stop_i && (state_q == S_RDATA);

  regsel_ptr u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .ai_i     (rx_byte_i[AI_BIT]),
    .ptr_i    (rx_byte_i[PTR_W-1:0]),
    .step_wr_i(step_wr),
    .step_rd_i(step_rd),
    .ai_o     (ai),
    .ptr_o    (ptr)
  );

  regsel_bank #(.DATA_W(8)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .ptr_i  (ptr),
    .wdata_i(rx_byte_i),
    .stat_i (stat_i),
    .ie_o   (ie_o),
    .ctrl_o (ctrl_o),
    .rdata_o(tx_byte_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      ack_q       <= 1'b0;
      ack_valid_q <= 1'b0;
    end else begin
      ack_valid_q <= 1'b0;
      if (start_i) begin
        state_q <= S_ADDR;
      end else if (stop_i) begin
        state_q <= S_IDLE;
      end else if (rx_valid_i) begin
        case (state_q)
          S_ADDR: begin
            ack_valid_q <= 1'b1;
            ack_q       <= hit;
            state_q     <= !hit ? S_IDLE : (rx_byte_i[0] ? S_RDATA : S_CMD);
          end
          S_CMD: begin
            ack_valid_q <= 1'b1;
            ack_q       <= cmd_ok(rx_byte_i);
            state_q     <= cmd_ok(rx_byte_i) ? S_WDATA : S_IDLE;
          end
          S_WDATA: begin
            ack_valid_q <= 1'b1;
            ack_q       <= (ptr != PTR_STAT);
            state_q     <= (ptr != PTR_STAT) ? S_WDATA : S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign ack_o       = ack_q;
  assign ack_valid_o = ack_valid_q;

  p_miss_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_in && state_q == S_ADDR && !hit) |=> (state_q == S_IDLE && !ack_o));
  p_nack_stat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_in && state_q == S_WDATA && ptr == PTR_STAT) |=> (ack_valid_o && !ack_o));
  p_ack_slot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(rx_valid_i));
  p_ai_loaded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> ai == $past(rx_byte_i[AI_BIT]));
endmodule

// File: tb/regsel_slave_test.sv
`timescale 1ns/1ps
module regsel_slave_test;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       start_i = 0, stop_i = 0, rx_valid_i = 0, rd_done_i = 0;
  logic [7:0] rx_byte_i = 0, stat_i = 8'h9A;
  logic [3:0] strap_i = 4'h5;
  logic [7:0] tx_byte_o, ie_o, ctrl_o;
  logic       ack_valid_o, ack_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  regsel_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .rd_done_i(rd_done_i),
    .strap_i(strap_i), .stat_i(stat_i), .tx_byte_o(tx_byte_o),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o), .ie_o(ie_o), .ctrl_o(ctrl_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask
  task automatic do_stop();
    stop_i = 1; @(negedge clk); stop_i = 0;
  endtask
  task automatic send(input logic [7:0] b, output logic a, output logic v);
    rx_byte_i = b; rx_valid_i = 1; @(negedge clk); rx_valid_i = 0;
    a = ack_o; v = ack_valid_o;
  endtask
  task automatic rd(output logic [7:0] d);
    d = tx_byte_o; rd_done_i = 1; @(negedge clk); rd_done_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a, v;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(ie_o == 0 && ctrl_o == 0, "R9 regs", {ie_o, ctrl_o}, 0);
    check(ack_valid_o == 0, "R9 ackv", ack_valid_o, 0);
    rst_ni = 1; @(negedge clk);
    do_start(); send(8'hEB, a, v);
    check(a && v, "R2 read addr ack", a, 1);
    rd(d); check(d == 8'h00, "R9 default ptr", d, 0);
    check(tx_byte_o == 8'h00, "R8 ptr held after read", tx_byte_o, 0);
    do_stop();

    // R4 preload with auto-increment, R11 timing
    do_start(); send(8'hEA, a, v);
    check(v, "R11 ack slot", v, 1);
    check(ack_valid_o == 1, "R11 one cycle", ack_valid_o, 1);
    @(negedge clk);
    check(ack_valid_o == 0, "R11 pulse ends", ack_valid_o, 0);
    send(8'h10, a, v); check(a && v, "R3 cmd 10", a, 1);
    send(8'h3C, a, v); check(a && v, "R4 ie ack", a, 1);
    send(8'hC5, a, v); check(a && v, "R4 ctrl ack", a, 1);
    do_stop();
    check(ie_o == 8'h3C, "R4 ie", ie_o, 8'h3C);
    check(ctrl_o == 8'hC5, "R4 ctrl", ctrl_o, 8'hC5);

    // R5 status write refused
    do_start(); send(8'hEA, a, v); send(8'h02, a, v);
    send(8'h55, a, v); check(v && !a, "R5 nack", a, 0);
    send(8'h66, a, v); check(!v, "R5 ends transfer", v, 0);
    do_stop();
    check(ie_o == 8'h3C && ctrl_o == 8'hC5, "R5 unchanged", {ie_o, ctrl_o}, 16'h3CC5);

    // R8 fixed pointer write and read, R10 repeated start
    do_start(); send(8'hEA, a, v); send(8'h01, a, v);
    send(8'h11, a, v); send(8'h22, a, v); check(a, "R8 ack", a, 1);
    do_stop();
    check(ctrl_o == 8'h22 && ie_o == 8'h3C, "R8 write", {ie_o, ctrl_o}, 16'h3C22);
    do_start(); send(8'hEA, a, v); send(8'h01, a, v);
    do_start(); send(8'hEB, a, v);
    rd(d); check(d == 8'h22, "R10 read", d, 8'h22);
    rd(d); check(d == 8'h22, "R8 read hold", d, 8'h22);
    do_stop();
    do_start(); send(8'hEA, a, v); send(8'h01, a, v); send(8'hC5, a, v); do_stop();

    // R6 read wrap
    do_start(); send(8'hEA, a, v); send(8'h11, a, v);
    do_start(); send(8'hEB, a, v);
    rd(d); check(d == 8'hC5, "R6 seq0", d, 8'hC5);
    rd(d); check(d == 8'h9A, "R6 seq1", d, 8'h9A);
    rd(d); check(d == 8'h3C, "R6 wrap", d, 8'h3C);
    rd(d); check(d == 8'hC5, "R6 seq3", d, 8'hC5);
    do_stop();

    // R7 write saturation
    do_start(); send(8'hEA, a, v); send(8'h10, a, v);
    send(8'h3C, a, v); send(8'hC5, a, v);
    send(8'h77, a, v); check(v && !a, "R7 nack at top", a, 0);
    do_start(); send(8'hEB, a, v);
    rd(d); check(d == 8'h9A, "R7 stuck at status", d, 8'h9A);
    rd(d); check(d == 8'h3C, "R6 wrap after", d, 8'h3C);
    do_stop();

    // R3 rejected code keeps pointer
    do_start(); send(8'hEA, a, v); send(8'h01, a, v);
    do_start(); send(8'hEA, a, v); send(8'h03, a, v);
    check(v && !a, "R3 nack 03", a, 0);
    do_start(); send(8'hEB, a, v);
    rd(d); check(d == 8'hC5, "R3 ptr kept", d, 8'hC5);
    do_stop();

    // R3/R10 command sweep
    for (int c = 0; c < 256; c++) begin
      logic exp_ok;
      logic [7:0] exp_d;
      exp_ok = (c[7:5] == 0) && (c[3:2] == 0) && (c[1:0] != 3);
      do_start(); send(8'hEA, a, v); send(8'(c), a, v);
      check(v && a == exp_ok, "R3 sweep", c, exp_ok);
      if (exp_ok) begin
        exp_d = (c[1:0] == 0) ? 8'h3C : (c[1:0] == 1) ? 8'hC5 : 8'h9A;
        do_start(); send(8'hEB, a, v);
        rd(d); check(d == exp_d, "R10 sweep read", d, exp_d);
      end
      do_stop();
    end

    // R1 address sweep over straps
    for (int s = 0; s < 4; s++) begin
      strap_i = (s == 0) ? 4'h5 : (s == 1) ? 4'hA : (s == 2) ? 4'h0 : 4'hF;
      for (int b = 0; b < 256; b++) begin
        logic exp_hit;
        exp_hit = (b[7:1] == {3'b111, strap_i});
        do_start(); send(8'(b), a, v);
        check(v && a == exp_hit, "R1 sweep", b, exp_hit);
        do_stop();
      end
    end
    strap_i = 4'h5;
    do_start(); send(8'h00, a, v); check(v && !a, "R1 miss nack", a, 0);
    send(8'h01, a, v); check(!v, "R1 ignored", v, 0);
    check(ctrl_o == 8'hC5 && ie_o == 8'h3C, "R1 no write", {ie_o, ctrl_o}, 16'h3CC5);
    do_stop();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule